// File: doc/BRIEF.md
# Ultrasonic Echo Pulse-Width Meter

This block runs one ranging cycle of a trigger-and-echo ultrasonic sensor. When it is idle and sees a start request, it raises the trigger pin for a fixed number of clock cycles, counted by a hardware timer. Once the trigger has ended, it waits for the echo pin to go high.

While it waits, one counter runs freely. The counter value is captured on the rising edge of echo and again on the falling edge that follows. The difference between the two captures is reported as the high time in clock cycles, together with a one-cycle done strobe.

The echo pin is asynchronous. It passes through a two-flop synchronizer before edge detection. If echo fails to rise, or fails to fall, within a set window, the block raises a timeout strobe and returns to idle. Converting the count into a distance is left to the consumer.

Top module: `echo_range_meter`

## Requirements
- R1: After reset, trig_o, done_o and timeout_o are 0 and width_o is 0.
- R2: A start_i sampled high while idle drives trig_o high from the next cycle for exactly TRIG_CYCLES cycles.
- R3: Echo edges are acted on only after the trigger pulse has ended. An echo pulse that starts and ends while trig_o is high produces no done, and the block goes on waiting for a fresh rise.
- R4: For a clean echo pulse held high for N clock cycles, with 1 <= N <= TMO_CYCLES, width_o equals N exactly.
- R5: done_o is a one-cycle pulse that is visible three clock edges after the echo falling edge (two synchronizer flops plus the capture register). width_o holds its value until the next done.
- R6: The width is computed modulo 2^CNT_W, so a counter wrap between the two captures still gives the correct width.
- R7: If echo does not rise within TMO_CYCLES cycles after the trigger ends, timeout_o pulses for one cycle exactly TMO_CYCLES cycles after the trigger ended, the block returns to idle, and no done is given.
- R8: If echo stays high for more than TMO_CYCLES cycles after its rise is captured, timeout_o pulses and no done is given. A pulse of exactly TMO_CYCLES cycles still completes with done.
- R9: A start_i that arrives while a measurement is in progress is ignored. No new trigger pulse starts, and the result of the measurement in flight is unchanged.
- R10: done_o and timeout_o are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request to run one ranging cycle |
| echo_i | input | 1 | Asynchronous echo pin from the sensor |
| trig_o | output | 1 | Timed trigger pulse to the sensor |
| width_o | output | CNT_W | Echo high time in clock cycles |
| done_o | output | 1 | One-cycle strobe: width_o is new |
| timeout_o | output | 1 | One-cycle strobe: echo rise or fall missed |

## Verification
The trigger is high on the cycle after start_i is sampled and stays high for exactly TRIG_CYCLES cycles. Done and a fall-side timeout are measured from the cycle in which echo changes: done is due three edges after echo falls, and a fall-side timeout is due TMO_CYCLES + 3 edges after echo rises. A rise-side timeout is due exactly TMO_CYCLES edges after the trigger drops. The bench drives all inputs on falling edges and samples the outputs on falling edges. It counts edges from each stimulus and compares the first edge at which a strobe appears against these figures, so a result that arrives one cycle early or one cycle late is caught. It sweeps every echo width from 1 to TMO_CYCLES + 3 on an 8-bit counter, so many of the captures straddle a counter wrap.

// File: rtl/echo_meter_pkg.sv
package echo_meter_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_TRIG    = 2'd1,
        ST_WAIT_HI = 2'd2,
        ST_WAIT_LO = 2'd3
    } meter_state_e;

endpackage

// File: rtl/echo_sync_edge.sv
module echo_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o,
    output logic fall_o
);
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0] pipe_d, pipe_q;

    // The synchronizer stages plus one history flop for edge detection.
    always_comb begin
        pipe_d = {pipe_q[DEPTH-2:0], async_i};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign rise_o =  pipe_q[STAGES-1] & ~pipe_q[STAGES];
    assign fall_o = ~pipe_q[STAGES-1] &  pipe_q[STAGES];

endmodule

// File: rtl/trig_pulse_gen.sv
module trig_pulse_gen #(
    parameter int TRIG_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire_i,
    output logic trig_o,
    output logic last_o
);
    localparam int TRG_W = $clog2(TRIG_CYCLES + 1);
    localparam logic [TRG_W-1:0] TRG_LOAD = TRG_W'(TRIG_CYCLES);
    localparam logic [TRG_W-1:0] TRG_ONE  = TRG_W'(1);

    typedef struct packed {
        logic [TRG_W-1:0] cnt;
        logic             trig;
    } trg_regs_t;

    trg_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (fire_i) begin
            r_d.cnt  = TRG_LOAD;
            r_d.trig = 1'b1;
        end else begin
            if (r_q.cnt != '0) r_d.cnt = r_q.cnt - TRG_ONE;
            r_d.trig = (r_q.cnt > TRG_ONE);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign trig_o = r_q.trig;
    assign last_o = (r_q.cnt == TRG_ONE);

    // The pin rises on the cycle after a fire request (R2).
    assert_fire_raises_pin_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fire_i |=> trig_o);

    // A fire request never lands on a pulse that is still running (R9).
    assert_no_fire_while_active_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fire_i |-> (r_q.cnt == '0));

endmodule

// File: rtl/capture_timer.sv
module capture_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_rise_i,
    input  logic             cap_fall_i,
    output logic [CNT_W-1:0] width_o
);
    typedef struct packed {
        logic [CNT_W-1:0] free;
        logic [CNT_W-1:0] stamp;
        logic [CNT_W-1:0] width;
    } cap_regs_t;

    cap_regs_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.free = r_q.free + CNT_W'(1);
        if (cap_rise_i) r_d.stamp = r_q.free;
        // Subtraction modulo 2^CNT_W makes a counter wrap harmless (R6).
        if (cap_fall_i) r_d.width = r_q.free - r_q.stamp;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign width_o = r_q.width;

    // A fall capture always follows its rise by at least one cycle (R4).
    assert_nonzero_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cap_fall_i |=> (width_o != '0));

endmodule

// File: rtl/echo_range_meter.sv
module echo_range_meter
    import echo_meter_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int TRIG_CYCLES = 1000,
    parameter int TMO_CYCLES  = 40000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             echo_i,
    output logic             trig_o,
    output logic [CNT_W-1:0] width_o,
    output logic             done_o,
    output logic             timeout_o
);
    localparam int TMO_W = $clog2(TMO_CYCLES + 1);
    localparam logic [TMO_W-1:0] TMO_LAST = TMO_W'(TMO_CYCLES - 1);

    typedef struct packed {
        meter_state_e     state;
        logic [TMO_W-1:0] tmo;
        logic             done;
        logic             timeout;
    } fsm_regs_t;

    fsm_regs_t r_d, r_q;

    logic echo_rise, echo_fall;
    logic fire, trig_last;
    logic cap_rise, cap_fall;

    echo_sync_edge #(.STAGES(2)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(echo_i),
        .rise_o (echo_rise),
        .fall_o (echo_fall)
    );

    trig_pulse_gen #(.TRIG_CYCLES(TRIG_CYCLES)) u_trig (
        .clk   (clk),
        .rst_n (rst_n),
        .fire_i(fire),
        .trig_o(trig_o),
        .last_o(trig_last)
    );

    capture_timer #(.CNT_W(CNT_W)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_rise_i(cap_rise),
        .cap_fall_i(cap_fall),
        .width_o   (width_o)
    );

    // Edges are captured only in the matching wait state (R3).
    assign fire     = (r_q.state == ST_IDLE) && start_i;
    assign cap_rise = (r_q.state == ST_WAIT_HI) && echo_rise;
    assign cap_fall = (r_q.state == ST_WAIT_LO) && echo_fall;

    always_comb begin
        r_d         = r_q;
        r_d.done    = 1'b0;
        r_d.timeout = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start_i) r_d.state = ST_TRIG;
            end
            ST_TRIG: begin
                if (trig_last) begin
                    r_d.state = ST_WAIT_HI;
                    r_d.tmo   = '0;
                end
            end
            ST_WAIT_HI: begin
                if (echo_rise) begin
                    r_d.state = ST_WAIT_LO;
                    r_d.tmo   = '0;
                end else if (r_q.tmo == TMO_LAST) begin
                    r_d.state   = ST_IDLE;
                    r_d.timeout = 1'b1;
                end else begin
                    r_d.tmo = r_q.tmo + TMO_W'(1);
                end
            end
            ST_WAIT_LO: begin
                if (echo_fall) begin
                    r_d.state = ST_IDLE;
                    r_d.done  = 1'b1;
                end else if (r_q.tmo == TMO_LAST) begin
                    r_d.state   = ST_IDLE;
                    r_d.timeout = 1'b1;
                end else begin
                    r_d.tmo = r_q.tmo + TMO_W'(1);
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state   <= ST_IDLE;
            r_q.tmo     <= '0;
            r_q.done    <= 1'b0;
            r_q.timeout <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign done_o    = r_q.done;
    assign timeout_o = r_q.timeout;

    // A busy block whose trigger has ended keeps the pin low (R9).
    assert_no_retrigger_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state != ST_IDLE && !trig_o) |=> !trig_o);

    assert_done_timeout_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && timeout_o));

    // done only ends a wait for the falling edge (R5).
    assert_done_from_fall_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(r_q.state) == ST_WAIT_LO);

    // A reported width lies inside the accepted window (R8).
    assert_width_in_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (width_o != '0 && width_o <= CNT_W'(TMO_CYCLES)));

endmodule

// File: tb/test_echo_range_meter.sv
module test_echo_range_meter;

    localparam int CNT_W = 8;
    localparam int TRIG  = 5;
    localparam int TMO   = 200;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic             echo_i = 1'b0;
    logic             trig_o;
    logic [CNT_W-1:0] width_o;
    logic             done_o;
    logic             timeout_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    echo_range_meter #(
        .CNT_W(CNT_W), .TRIG_CYCLES(TRIG), .TMO_CYCLES(TMO)
    ) i_echo_range_meter (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .echo_i(echo_i),
        .trig_o(trig_o), .width_o(width_o), .done_o(done_o), .timeout_o(timeout_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Start a cycle and check the trigger pulse; ends on the edge after it drops.
    task automatic fire_and_check_trig(input bit echo_blip);
        int hi;
        hi = 0;
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        for (int i = 0; i < TRIG; i++) begin
            if (trig_o) hi++;
            if (echo_blip && i == 0) echo_i = 1'b1;
            if (echo_blip && i == 1) echo_i = 1'b0;
            @(negedge clk);
        end
        chk(hi == TRIG, "R2 trigger high cycles", hi, TRIG);
        chk(trig_o == 1'b0, "R2 trigger low after pulse", int'(trig_o), 0);
    endtask

    task automatic measure(input int n, input int dly, input bit poke);
        int first, lim, w, nxt;
        bit got_done, got_to, trig_bad;
        first = 0; got_done = 0; got_to = 0; trig_bad = 0; w = 0; nxt = 0;
        fire_and_check_trig(1'b0);
        repeat (dly) @(negedge clk);
        echo_i = 1'b1;
        lim = (n <= TMO) ? n + 6 : TMO + 6;
        for (int j = 1; j <= lim; j++) begin
            @(negedge clk);
            if (j == n) echo_i = 1'b0;
            if (poke && j == 2) start_i = 1'b1;
            if (poke && j == 3) start_i = 1'b0;
            if (trig_o) trig_bad = 1;
            if (first != 0 && j == first + 1) nxt = int'(done_o) + int'(timeout_o);
            if (first == 0 && (done_o || timeout_o)) begin
                first = j; got_done = done_o; got_to = timeout_o; w = int'(width_o);
            end
        end
        echo_i = 1'b0;
        repeat (6) @(negedge clk);
        chk(!trig_bad, "R9 no trigger during measurement", int'(trig_bad), 0);
        chk(!(got_done && got_to), "R10 done and timeout together", 1, 0);
        chk(nxt == 0, "R5 strobe lasts one cycle", nxt, 0);
        if (n <= TMO) begin
            chk(got_done, "R5 done seen", int'(got_done), 1);
            chk(first == n + 3, "R5 done latency after fall", first, n + 3);
            chk(w == n, "R4 R6 width", w, n);
            chk(int'(width_o) == n, "R5 width held after done", int'(width_o), n);
            if (poke) chk(w == n, "R9 width unchanged by start", w, n);
        end else begin
            chk(got_to && !got_done, "R8 timeout on long echo", int'(got_to), 1);
            chk(first == TMO + 3, "R8 timeout latency after rise", first, TMO + 3);
        end
    endtask

    task automatic rise_timeout(input bit echo_blip);
        int first;
        bit saw_done;
        first = 0; saw_done = 0;
        fire_and_check_trig(echo_blip);
        for (int j = 1; j <= TMO + 10; j++) begin
            @(negedge clk);
            if (done_o) saw_done = 1;
            if (first == 0 && timeout_o) first = j;
        end
        chk(first == TMO, "R7 rise timeout cycle", first, TMO);
        chk(!saw_done, "R7 no done on rise timeout", int'(saw_done), 0);
        if (echo_blip) chk(!saw_done && first == TMO, "R3 echo during trigger ignored", first, TMO);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(trig_o == 0 && done_o == 0 && timeout_o == 0 && width_o == 0,
            "R1 reset state", int'(trig_o) + int'(done_o) + int'(timeout_o) + int'(width_o), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(trig_o == 0 && done_o == 0, "R1 idle after reset", int'(trig_o), 0);

        rise_timeout(1'b0);
        rise_timeout(1'b1);

        // Sweep every width; the 8-bit counter wraps across many captures (R6).
        for (int n = 1; n <= TMO + 3; n++) begin
            measure(n, n % 4, (n % 17) == 0);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule